// File: doc/BRIEF.md
# Command Bit and Task Identifier Register Bank

This block is a small memory-mapped register bank that sits on a shared peripheral bus. Three bus masters may reach it, but arbitration happens upstream, so the bank sees at most one access per cycle. It holds an eight-bit task identifier and five single-bit command registers. Each command bit has its own address and drives one control pin. Two of those pins are active low and three are active high.

Each command bit is written and read only through bit 0 of the data word. Writing one command bit never disturbs another. The task register is a plain read/write byte, so software can detect that the card is present by writing a pattern and reading it back. Every register answers both at its primary offset and at an alias 0x10000 above it, because address bit 16 is not decoded.

Accesses are qualified by `bus_req`, with `bus_we` selecting a write. A write takes effect at the clock edge that accepts it. A read is answered one cycle later with `bus_rvalid` high. The access sequencer has two states. `ST_IDLE` moves to `ST_RDATA` when a read is accepted and stays in `ST_IDLE` otherwise. `ST_RDATA` stays in `ST_RDATA` on a further read and returns to `ST_IDLE` on a write or on no request.

Top module: `cmd_task_bank`

## Requirements
- R1: After reset, the processor-reset command bit reads 1, so `proc_rst_n` is low and the processor is held in reset. The other four command bits read 0: cache disabled (`cache_en_n` high), DMA off, both DMA mode pins low. `task_id` is 0x00.
- R2: A write to a command bit loads `bus_wdata[0]` into that bit (1 sets it, 0 clears it). Bits 15..1 of the write data are ignored, and no other register changes. Reads never change any register.
- R3: A read of a command bit returns its logical value in bit 0 and zeros in bits 15..1, whatever the polarity of its pin.
- R4: `proc_rst_n` and `cache_en_n` drive the inverse of their command bits. `dma_active`, `dma_mode[0]` and `dma_mode[1]` drive their command bits unchanged.
- R5: The decoded offsets in `bus_addr[15:0]` are:
  - processor reset 0x4637
  - cache enable 0x4A0F
  - DMA active 0x4827
  - DMA mode 0 0x482F
  - DMA mode 1 0x4837
  - task register 0x4C07
- R6: A write to the task register loads `bus_wdata[7:0]` into `task_id` and ignores bits 15..8. A read of it returns `{8'h00, task_id}`.
- R7: `bus_addr[16]` is not decoded, so every register behaves identically at its offset plus 0x10000.
- R8: A write to any other address changes nothing, and a read of it returns 0x0000.
- R9: A read accepted at one clock edge raises `bus_rvalid` for the following cycle, with the data sampled at that edge. While `bus_rvalid` is low, `bus_rdata` is 0x0000. A read accepted right after a write returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 17 | Byte address; bit 16 is the alias bit and is ignored |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rvalid is high, else zero |
| bus_rvalid | output | 1 | Read response strobe, one cycle after a read is accepted |
| proc_rst_n | output | 1 | Processor reset, active low |
| cache_en_n | output | 1 | Cache enable, active low |
| dma_active | output | 1 | DMA run enable, active high |
| dma_mode | output | 2 | DMA mode bits 1..0, active high |
| task_id | output | 8 | Current task identifier |

## Verification
A read response and a newly accepted access can share a cycle. The `ST_RDATA` response to one read is on the port in the same cycle that the next request is taken. The bench provokes this in two ways. In the first, a task-register write is followed at once by a read of the same register; the read must return the new byte. In the second, a read is followed at once by a write; the response must still carry the old byte, while `task_id` already shows the new one a cycle later. The response must then drop back to zero with `bus_rvalid` low.

// File: rtl/cmd_task_bank_pkg.sv
package cmd_task_bank_pkg;

    localparam int NUM_CMD = 5;

    // command bit indices
    localparam int IDX_RST   = 0;
    localparam int IDX_CACHE = 1;
    localparam int IDX_DMA   = 2;
    localparam int IDX_MODE0 = 3;
    localparam int IDX_MODE1 = 4;

    // pin polarity per command bit (1 = active low) and reset value
    localparam logic [NUM_CMD-1:0] CMD_ACT_LOW = 5'b00011;
    localparam logic [NUM_CMD-1:0] CMD_RST_VAL = 5'b00001;

    localparam logic [15:0] TASK_OFF = 16'h4C07;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_RDATA = 1'b1
    } acc_state_e;

    function automatic logic [15:0] cmd_offset(input int idx);
        logic [15:0] off;
        case (idx)
            IDX_RST:   off = 16'h4637;
            IDX_CACHE: off = 16'h4A0F;
            IDX_DMA:   off = 16'h4827;
            IDX_MODE0: off = 16'h482F;
            IDX_MODE1: off = 16'h4837;
            default:   off = 16'hFFFF;
        endcase
        return off;
    endfunction

    function automatic logic off_is_cmd(input logic [15:0] off);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_CMD; i++) begin
            if (off == cmd_offset(i)) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/cmd_task_bank_decode.sv
module cmd_task_bank_decode
    import cmd_task_bank_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_CMD-1:0] cmd_sel,
    output logic               task_sel
);
    localparam int ALIAS_W = ADDR_W - OFF_W;

    logic [OFF_W-1:0]   off;
    logic [ALIAS_W-1:0] unused_alias;

    assign off          = addr[OFF_W-1:0];
    assign unused_alias = addr[ADDR_W-1:OFF_W];

    for (genvar i = 0; i < NUM_CMD; i++) begin : g_cmd_dec
        assign cmd_sel[i] = (off == OFF_W'(cmd_offset(i)));
    end

    assign task_sel = (off == OFF_W'(TASK_OFF));

endmodule

// File: rtl/cmd_task_bank_bit.sv
module cmd_task_bank_bit #(
    parameter logic RST_VAL = 1'b0,
    parameter logic ACT_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wbit,
    output logic state_q,
    output logic pin
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= RST_VAL;
        else if (wr_en) state_q <= wbit;
    end

    if (ACT_LOW) begin : g_low
        assign pin = ~state_q;
    end else begin : g_high
        assign pin = state_q;
    end

endmodule

// File: rtl/cmd_task_bank_seq.sv
module cmd_task_bank_seq
    import cmd_task_bank_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wr_stb,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    acc_state_e        state_q, state_d;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_acc;

    assign rd_acc = req & ~we;
    assign wr_stb = req & we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_acc) rdata_q <= rd_word;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = rd_acc ? ST_RDATA : ST_IDLE;
            ST_RDATA: state_d = rd_acc ? ST_RDATA : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rvalid = (state_q == ST_RDATA);
        rdata  = rvalid ? rdata_q : '0;
    end

endmodule

// File: rtl/cmd_task_bank.sv
module cmd_task_bank
    import cmd_task_bank_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int OFF_W  = 16,
    parameter int DATA_W = 16,
    parameter int TASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              proc_rst_n,
    output logic              cache_en_n,
    output logic              dma_active,
    output logic [1:0]        dma_mode,
    output logic [TASK_W-1:0] task_id
);
    logic [NUM_CMD-1:0] cmd_sel, cmd_q, cmd_pin;
    logic               task_sel, wr_stb, cmd_rd_bit;
    logic [DATA_W-1:0]  rd_word;
    logic [DATA_W-TASK_W-1:0] unused_wdata;

    assign unused_wdata = bus_wdata[DATA_W-1:TASK_W];

    cmd_task_bank_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
        .addr     (bus_addr),
        .cmd_sel  (cmd_sel),
        .task_sel (task_sel)
    );

    cmd_task_bank_seq #(.DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .we      (bus_we),
        .rd_word (rd_word),
        .wr_stb  (wr_stb),
        .rvalid  (bus_rvalid),
        .rdata   (bus_rdata)
    );

    for (genvar i = 0; i < NUM_CMD; i++) begin : g_bit
        cmd_task_bank_bit #(
            .RST_VAL (CMD_RST_VAL[i]),
            .ACT_LOW (CMD_ACT_LOW[i])
        ) u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_stb & cmd_sel[i]),
            .wbit    (bus_wdata[0]),
            .state_q (cmd_q[i]),
            .pin     (cmd_pin[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  task_id <= '0;
        else if (wr_stb && task_sel) task_id <= bus_wdata[TASK_W-1:0];
    end

    assign cmd_rd_bit = |(cmd_sel & cmd_q);

    always_comb begin
        rd_word = '0;
        if (task_sel)      rd_word[TASK_W-1:0] = task_id;
        else if (|cmd_sel) rd_word[0]          = cmd_rd_bit;
    end

    assign proc_rst_n  = cmd_pin[IDX_RST];
    assign cache_en_n  = cmd_pin[IDX_CACHE];
    assign dma_active  = cmd_pin[IDX_DMA];
    assign dma_mode[0] = cmd_pin[IDX_MODE0];
    assign dma_mode[1] = cmd_pin[IDX_MODE1];

endmodule

// File: rtl/cmd_task_bank_chk.sv
module cmd_task_bank_chk
    import cmd_task_bank_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_we,
    input logic [16:0] bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        bus_rvalid,
    input logic        proc_rst_n,
    input logic        cache_en_n,
    input logic        dma_active,
    input logic [1:0]  dma_mode,
    input logic [7:0]  task_id
);
    logic        rd_acc, wr_acc, cmd_hit, task_hit, rst_hit;
    logic [12:0] pins;
    logic        unused_hi;

    assign unused_hi = bus_addr[16];
    assign rd_acc    = bus_req && !bus_we;
    assign wr_acc    = bus_req && bus_we;
    assign cmd_hit   = off_is_cmd(bus_addr[15:0]);
    assign task_hit  = (bus_addr[15:0] == TASK_OFF);
    assign rst_hit   = (bus_addr[15:0] == 16'h4637);
    assign pins      = {task_id, dma_mode, dma_active, cache_en_n, proc_rst_n};

    // R9
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> bus_rvalid);
    // R9
    no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !bus_rvalid);
    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> bus_rdata == 16'h0000);
    // R3
    cmd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && cmd_hit) |=> bus_rdata[15:1] == 15'h0);
    // R6
    task_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> bus_rdata[15:8] == 8'h00);
    // R6
    task_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && task_hit) |=> task_id == $past(bus_wdata[7:0]));
    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !cmd_hit && !task_hit) |=> $stable(pins));
    // R2
    read_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_acc |=> $stable(pins));
    // R4
    rst_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && rst_hit) |=> bus_rdata[0] == !proc_rst_n);

endmodule

bind cmd_task_bank cmd_task_bank_chk u_chk (.*);

// File: tb/cmd_task_bank_test.sv
module cmd_task_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        proc_rst_n, cache_en_n, dma_active;
    logic [1:0]  dma_mode;
    logic [7:0]  task_id;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cmd_task_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .proc_rst_n(proc_rst_n), .cache_en_n(cache_en_n),
        .dma_active(dma_active), .dma_mode(dma_mode), .task_id(task_id)
    );

    // {we, addr, wdata / expected rdata, expected pins}
    // pins = {task_id, dma_mode[1], dma_mode[0], dma_active, cache_en_n, proc_rst_n}
    localparam int NV = 20;
    localparam logic [46:0] VECS [0:NV-1] = '{
        {1'b1, 17'h04637, 16'h0000, 13'h0003}, // R2 R4 release reset
        {1'b0, 17'h04637, 16'h0000, 13'h0003}, // R3
        {1'b1, 17'h14A0F, 16'h0001, 13'h0001}, // R7 R4 cache on via alias
        {1'b0, 17'h04A0F, 16'h0001, 13'h0001}, // R3
        {1'b1, 17'h04827, 16'hFFFE, 13'h0001}, // R2 upper bits ignored
        {1'b1, 17'h04827, 16'h0001, 13'h0005}, // R4 dma on
        {1'b1, 17'h1482F, 16'h0001, 13'h000D}, // R7 mode0
        {1'b1, 17'h04837, 16'h0003, 13'h001D}, // R2 mode1
        {1'b0, 17'h14837, 16'h0001, 13'h001D}, // R7
        {1'b1, 17'h04C07, 16'h12A5, 13'h14BD}, // R6
        {1'b0, 17'h14C07, 16'h00A5, 13'h14BD}, // R7 R6
        {1'b1, 17'h0482F, 16'h0000, 13'h14B5}, // R2 clear mode0 only
        {1'b0, 17'h0482F, 16'h0000, 13'h14B5}, // R3
        {1'b1, 17'h04638, 16'h0001, 13'h14B5}, // R8 unmapped write
        {1'b0, 17'h04638, 16'h0000, 13'h14B5}, // R8 unmapped read
        {1'b1, 17'h04637, 16'h0001, 13'h14B4}, // R4 reset asserted, pin low
        {1'b0, 17'h04637, 16'h0001, 13'h14B4}, // R3 logical value
        {1'b0, 17'h04A0F, 16'h0001, 13'h14B4}, // R5
        {1'b1, 17'h14C07, 16'h005A, 13'h0B54}, // R6 via alias
        {1'b0, 17'h04C07, 16'h005A, 13'h0B54}  // R6
    };
    localparam int REQ_OF [0:NV-1] = '{2,3,7,3,2,4,7,2,7,6,7,2,3,8,8,4,3,5,6,6};

    function automatic logic [12:0] pins_now();
        return {task_id, dma_mode, dma_active, cache_en_n, proc_rst_n};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic req, input logic we, input logic [16:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_req = req; bus_we = we; bus_addr = a; bus_wdata = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pins after reset", 32'(pins_now()), 32'h0002);
        check("R9 rvalid idle", 32'(bus_rvalid), 32'h0);
        drive(1'b1, 1'b0, 17'h04637, 16'h0);
        drive(1'b0, 1'b0, 17'h0, 16'h0);
        check("R1 reset bit readback", 32'(bus_rdata), 32'h0001);

        for (int i = 0; i < NV; i++) begin
            logic [46:0] v;
            v = VECS[i];
            drive(1'b1, v[46], v[45:29], v[28:13]);
            drive(1'b0, 1'b0, 17'h0, 16'h0);
            if (!v[46]) begin
                check($sformatf("R%0d vec %0d rvalid", REQ_OF[i], i), 32'(bus_rvalid), 32'h1);
                check($sformatf("R%0d vec %0d rdata", REQ_OF[i], i), 32'(bus_rdata), 32'(v[28:13]));
            end else begin
                check($sformatf("R%0d vec %0d no rvalid", REQ_OF[i], i), 32'(bus_rvalid), 32'h0);
            end
            check($sformatf("R%0d vec %0d pins", REQ_OF[i], i), 32'(pins_now()), 32'(v[12:0]));
        end

        // R9 write then read back-to-back
        drive(1'b1, 1'b1, 17'h04C07, 16'h0033);
        drive(1'b1, 1'b0, 17'h04C07, 16'h0);
        drive(1'b0, 1'b0, 17'h0, 16'h0);
        check("R9 read after write", 32'(bus_rdata), 32'h0033);
        check("R9 rvalid after write-read", 32'(bus_rvalid), 32'h1);

        // R9 read then write back-to-back: response keeps old byte
        drive(1'b1, 1'b0, 17'h04C07, 16'h0);
        drive(1'b1, 1'b1, 17'h04C07, 16'h0044);
        check("R9 response during write", 32'(bus_rdata), 32'h0033);
        check("R9 rvalid during write", 32'(bus_rvalid), 32'h1);
        drive(1'b0, 1'b0, 17'h0, 16'h0);
        check("R6 task after write", 32'(task_id), 32'h44);
        check("R9 rvalid drop", 32'(bus_rvalid), 32'h0);
        check("R9 rdata zero when idle", 32'(bus_rdata), 32'h0);

        // R1 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pins after second reset", 32'(pins_now()), 32'h0002);
        drive(1'b1, 1'b0, 17'h14C07, 16'h0);
        drive(1'b0, 1'b0, 17'h0, 16'h0);
        check("R1 task reads zero", 32'(bus_rdata), 32'h0000);

        finish_run();
    end

endmodule